// File: doc/BRIEF.md
# Hold-Interval Pseudo-Random Self-Test Sequencer

This block drives a sequential circuit under test with pseudo-random stimulus that is kept constant for a programmable number of clock cycles, written k here. Each stimulus word is split in two. The low part feeds the circuit's primary inputs. The high part is a parallel-load image for the scanned subset of its flip-flops, so scan may be partial: flip-flops outside that image simply run on. The circuit keeps being clocked for the whole hold interval, so its internal state moves forward under a fixed input. Its primary outputs are folded into a multiple-input signature register on every one of those cycles.

Software picks k ahead of time from offline analysis and writes it together with a nonzero seed and the number of stimulus words to apply. A start pulse launches the run. When every word has completed its full hold interval, the block raises done and keeps the final signature for readout. With k equal to one, the block reduces to ordinary per-cycle random testing.

Top module: `hold_bist_top`

## Requirements
- R1: After reset, busy_o, done_o, scan_ld_o, pi_o, scan_o and sig_o are all zero. The configuration holds k = 1, seed = 1 and word count = 1.
- R2: A start_i pulse seen while busy_o is low causes the following effects one cycle later. busy_o rises, done_o falls, {scan_o, pi_o} equals the seed, and sig_o is cleared to zero.
- R3: Each stimulus word stays on {scan_o, pi_o} for exactly k cycles. The next word is one step of a right-shifting Galois LFSR: v' = (v >> 1) XOR (v[0] ? 16'hB400 : 0).
- R4: scan_ld_o is high in the first cycle of every hold interval and low in every other cycle.
- R5: In every cycle that busy_o is high, the signature advances. On the next edge it becomes s' = ((s >> 1) XOR (s[0] ? 16'hB400 : 0)) XOR zero-extended resp_i.
- R6: The run covers exactly count × k busy cycles. done_o then rises and busy_o falls together. sig_o and the stimulus stay frozen. done_o remains high until the next accepted start.
- R7: With k = 1, a new stimulus word and a scan_ld_o pulse appear in every busy cycle.
- R8: A configuration write issued while busy_o is high has no effect on later runs.
- R9: A write of zero to k, to the seed or to the word count is ignored, and the previous value is kept.
- R10: A start_i pulse while busy_o is high is ignored, and the running test continues unchanged.
- R11: cfg_sel_i selects the target of a configuration write. 0 selects k, taken from cfg_wdata_i[7:0]. 1 selects the seed, taken from all 16 bits. 2 selects the word count, taken from cfg_wdata_i[11:0]. 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the circuit under test |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches a run when no run is in progress |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 2 | Configuration target select |
| cfg_wdata_i | input | 16 | Configuration write data |
| resp_i | input | 8 | Primary outputs of the circuit under test |
| pi_o | output | 10 | Stimulus for the primary inputs |
| scan_o | output | 6 | Parallel-load image for the scanned flip-flops |
| scan_ld_o | output | 1 | One-cycle strobe that loads scan_o into the scan cells |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run completed |
| sig_o | output | 16 | Response signature |

## Verification
All outputs are registered. After an accepted start, busy_o, the seed word and the first scan_ld_o pulse all appear one clock later. Each later word appears one clock after the last cycle of its predecessor's hold interval. resp_i applied in a busy cycle shows up in sig_o one clock later, and done_o rises one clock after the final busy cycle. The bench therefore updates a behavioural model at each rising edge from the inputs that held across that edge. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/hold_bist_pkg.sv
package hold_bist_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_st_e;

  localparam logic [1:0] CFG_SEL_K    = 2'd0;
  localparam logic [1:0] CFG_SEL_SEED = 2'd1;
  localparam logic [1:0] CFG_SEL_NVEC = 2'd2;

endpackage

// File: rtl/bist_galois_step.sv
module bist_galois_step #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'hB400
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);

  always_comb begin
    nxt_o = {1'b0, cur_i[W-1:1]};
    if (cur_i[0]) nxt_o = nxt_o ^ POLY;
  end

endmodule

// File: rtl/bist_cfg_regs.sv
module bist_cfg_regs
  import hold_bist_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int K_W   = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_i,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [VEC_W-1:0] wdata_i,
  output logic [K_W-1:0]   k_o,
  output logic [VEC_W-1:0] seed_o,
  output logic [CNT_W-1:0] nvec_o
);

  logic [K_W-1:0]   k_q;
  logic [VEC_W-1:0] seed_q;
  logic [CNT_W-1:0] nvec_q;
  logic             wr_ok;

  assign wr_ok = we_i && !lock_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q    <= K_W'(1);
      seed_q <= VEC_W'(1);
      nvec_q <= CNT_W'(1);
    end else if (wr_ok) begin
      case (sel_i)
        CFG_SEL_K:    if (wdata_i[K_W-1:0] != '0)   k_q    <= wdata_i[K_W-1:0];
        CFG_SEL_SEED: if (wdata_i != '0)            seed_q <= wdata_i;
        CFG_SEL_NVEC: if (wdata_i[CNT_W-1:0] != '0) nvec_q <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign k_o    = k_q;
  assign seed_o = seed_q;
  assign nvec_o = nvec_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> ($stable(k_q) && $stable(seed_q) && $stable(nvec_q))); // R8
  AST_CFG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (k_q != '0) && (seed_q != '0) && (nvec_q != '0)); // R9

endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import hold_bist_pkg::*;
#(
  parameter int K_W   = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [K_W-1:0]   k_i,
  input  logic [CNT_W-1:0] nvec_i,
  output logic             accept_o,
  output logic             step_o,
  output logic             run_o,
  output logic             done_o,
  output logic             sld_o
);

  seq_st_e          st_q;
  logic [K_W-1:0]   hold_q;
  logic [CNT_W-1:0] idx_q;
  logic             run, last_cyc, last_vec, sld_q;

  assign run      = (st_q == SEQ_RUN);
  assign last_cyc = run && (hold_q == '0);
  assign last_vec = (idx_q == nvec_i - CNT_W'(1));
  assign accept_o = start_i && !run;
  assign step_o   = last_cyc && !last_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      hold_q <= '0;
      idx_q  <= '0;
      sld_q  <= 1'b0;
    end else begin
      sld_q <= 1'b0;
      if (accept_o) begin
        st_q   <= SEQ_RUN;
        hold_q <= k_i - K_W'(1);
        idx_q  <= '0;
        sld_q  <= 1'b1;
      end else if (run) begin
        if (hold_q != '0) begin
          hold_q <= hold_q - K_W'(1);
        end else if (last_vec) begin
          st_q <= SEQ_DONE;
        end else begin
          hold_q <= k_i - K_W'(1);
          idx_q  <= idx_q + CNT_W'(1);
          sld_q  <= 1'b1;
        end
      end
    end
  end

  assign run_o  = run;
  assign done_o = (st_q == SEQ_DONE);
  assign sld_o  = sld_q;

  AST_HOLD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (hold_q < k_i)); // R3
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (idx_q < nvec_i)); // R6
  AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    sld_q |-> run); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (run && hold_q != '0) |=> (run && !sld_q)); // R10

endmodule

// File: rtl/bist_pattern_reg.sv
module bist_pattern_reg #(
  parameter int               VEC_W = 16,
  parameter logic [VEC_W-1:0] POLY  = 16'hB400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [VEC_W-1:0] seed_i,
  output logic [VEC_W-1:0] vec_o
);

  logic [VEC_W-1:0] vec_q, vec_nxt;

  bist_galois_step #(.W(VEC_W), .POLY(POLY)) u_step (
    .cur_i (vec_q),
    .nxt_o (vec_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)         vec_q <= '0;
    else if (load_i) vec_q <= seed_i;
    else if (step_i) vec_q <= vec_nxt;
  end

  assign vec_o = vec_q;

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(vec_q)); // R3

endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int               SIG_W  = 16,
  parameter int               RESP_W = 8,
  parameter logic [SIG_W-1:0] POLY   = 16'hB400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [RESP_W-1:0] resp_i,
  output logic [SIG_W-1:0]  sig_o
);

  logic [SIG_W-1:0] sig_q, sig_sh;

  bist_galois_step #(.W(SIG_W), .POLY(POLY)) u_step (
    .cur_i (sig_q),
    .nxt_o (sig_sh)
  );

  always_ff @(posedge clk) begin
    if (rst)        sig_q <= '0;
    else if (clr_i) sig_q <= '0;
    else if (en_i)  sig_q <= sig_sh ^ SIG_W'(resp_i);
  end

  assign sig_o = sig_q;

  AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !en_i) |=> $stable(sig_q)); // R6

endmodule

// File: rtl/hold_bist_top.sv
module hold_bist_top #(
  parameter int PI_W      = 10,
  parameter int SCAN_W    = 6,
  parameter int K_W       = 8,
  parameter int CNT_W     = 12,
  parameter int RESP_W    = 8,
  parameter int SIG_W     = 16,
  parameter logic [PI_W+SCAN_W-1:0] VEC_POLY = 16'hB400,
  parameter logic [SIG_W-1:0]       SIG_POLY = 16'hB400
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   cfg_we_i,
  input  logic [1:0]             cfg_sel_i,
  input  logic [PI_W+SCAN_W-1:0] cfg_wdata_i,
  input  logic [RESP_W-1:0]      resp_i,
  output logic [PI_W-1:0]        pi_o,
  output logic [SCAN_W-1:0]      scan_o,
  output logic                   scan_ld_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [SIG_W-1:0]       sig_o
);

  localparam int VEC_W = PI_W + SCAN_W;

  logic [K_W-1:0]   k_cfg;
  logic [VEC_W-1:0] seed_cfg, vec;
  logic [CNT_W-1:0] nvec_cfg;
  logic             accept, step, run, done, sld;

  bist_cfg_regs #(.VEC_W(VEC_W), .K_W(K_W), .CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .lock_i  (run),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .k_o     (k_cfg),
    .seed_o  (seed_cfg),
    .nvec_o  (nvec_cfg)
  );

  bist_seq #(.K_W(K_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .k_i      (k_cfg),
    .nvec_i   (nvec_cfg),
    .accept_o (accept),
    .step_o   (step),
    .run_o    (run),
    .done_o   (done),
    .sld_o    (sld)
  );

  bist_pattern_reg #(.VEC_W(VEC_W), .POLY(VEC_POLY)) u_pat (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .step_i (step),
    .seed_i (seed_cfg),
    .vec_o  (vec)
  );

  bist_misr #(.SIG_W(SIG_W), .RESP_W(RESP_W), .POLY(SIG_POLY)) u_misr (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (accept),
    .en_i   (run),
    .resp_i (resp_i),
    .sig_o  (sig_o)
  );

  assign pi_o      = vec[PI_W-1:0];
  assign scan_o    = vec[VEC_W-1:PI_W];
  assign scan_ld_o = sld;
  assign busy_o    = run;
  assign done_o    = done;

  AST_START_LOADS_SEED: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy_o && scan_ld_o && !done_o && {scan_o, pi_o} == $past(seed_cfg))); // R2
  AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (vec != '0)); // R3
  AST_RUN_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o)); // R6
  AST_STROBE_NEW_VEC: assert property (@(posedge clk) disable iff (rst)
    (scan_ld_o && $past(busy_o)) |-> (vec != $past(vec))); // R4

endmodule

// File: tb/hold_bist_top_tb.sv
module hold_bist_top_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, cfg_we_i;
  logic [1:0]  cfg_sel_i;
  logic [15:0] cfg_wdata_i;
  logic [7:0]  resp_i;
  logic [9:0]  pi_o;
  logic [5:0]  scan_o;
  logic        scan_ld_o, busy_o, done_o;
  logic [15:0] sig_o;

  always #4 clk = ~clk;

  hold_bist_top u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .resp_i(resp_i),
    .pi_o(pi_o), .scan_o(scan_o), .scan_ld_o(scan_ld_o), .busy_o(busy_o),
    .done_o(done_o), .sig_o(sig_o)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural reference
  int          m_state;   // 0 idle, 1 running, 2 finished
  int          m_left;    // cycles left in current hold after this one
  int          m_words;   // words fully started
  int          m_k, m_n;
  logic [15:0] m_seed, m_vec, m_sig;
  logic        m_sld;

  function automatic logic [15:0] gal(input logic [15:0] v);
    return (v >> 1) ^ (v[0] ? 16'hB400 : 16'h0000);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_state = 0; m_left = 0; m_words = 0;
      m_k = 1; m_n = 1; m_seed = 16'd1; m_vec = '0; m_sig = '0; m_sld = 1'b0;
    end else begin
      int k_old, n_old;
      logic [15:0] s_old;
      k_old = m_k; n_old = m_n; s_old = m_seed;
      if (cfg_we_i && m_state != 1) begin
        if (cfg_sel_i == 2'd0 && cfg_wdata_i[7:0] != 0)  m_k = cfg_wdata_i[7:0];
        if (cfg_sel_i == 2'd1 && cfg_wdata_i != 0)       m_seed = cfg_wdata_i;
        if (cfg_sel_i == 2'd2 && cfg_wdata_i[11:0] != 0) m_n = cfg_wdata_i[11:0];
      end
      if (m_state != 1 && start_i) begin
        m_state = 1; m_vec = s_old; m_left = k_old - 1; m_words = 1;
        m_sig = '0; m_sld = 1'b1;
      end else if (m_state == 1) begin
        m_sig = gal(m_sig) ^ {8'h00, resp_i};
        m_sld = 1'b0;
        if (m_left > 0) m_left--;
        else if (m_words == n_old) m_state = 2;
        else begin
          m_vec = gal(m_vec); m_left = k_old - 1; m_words++; m_sld = 1'b1;
        end
      end else m_sld = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3", "vector", {16'h0, scan_o, pi_o}, {16'h0, m_vec});
      chk("R4", "scan_ld", {31'h0, scan_ld_o}, {31'h0, m_sld});
      chk("R2", "busy", {31'h0, busy_o}, {31'h0, m_state == 1});
      chk("R6", "done", {31'h0, done_o}, {31'h0, m_state == 2});
      chk("R5", "signature", {16'h0, sig_o}, {16'h0, m_sig});
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  always @(negedge clk) resp_i <= 8'($urandom);

  task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  // run and count busy cycles against expected total
  task automatic run_count(input string req, input int exp_busy);
    int n = 0;
    pulse_start();
    while (!done_o) begin
      if (busy_o) n++;
      @(negedge clk);
    end
    chk(req, "busy cycle count", n, exp_busy);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; cfg_we_i = 1'b0; cfg_sel_i = '0; cfg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1", "reset outputs", {busy_o, done_o, scan_ld_o, scan_o, pi_o, sig_o}, '0);
    // R1 default config: k=1, count=1, seed=1
    run_count("R1", 1);
    chk("R1", "default seed", {16'h0, scan_o, pi_o}, 32'h1);

    // R11 encodings, k=3 seed=ACE1 count=5
    cfg(2'd0, 16'h0003);
    cfg(2'd1, 16'hACE1);
    cfg(2'd2, 16'h0005);
    cfg(2'd3, 16'hFFFF); // R11 sel 3 writes nothing
    run_count("R11", 15);
    chk("R6", "done held", {31'h0, done_o}, 32'h1);
    repeat (5) @(negedge clk);
    chk("R6", "done still held", {31'h0, done_o}, 32'h1);

    // R7 k=1, eight words
    cfg(2'd0, 16'h0001);
    cfg(2'd2, 16'h0008);
    run_count("R7", 8);

    // R9 zero writes ignored
    cfg(2'd0, 16'h0000);
    cfg(2'd1, 16'h0000);
    cfg(2'd2, 16'h0000);
    run_count("R9", 8);

    // R8 writes during run ignored; R10 start during run ignored
    cfg(2'd0, 16'h0004);
    cfg(2'd2, 16'h0003);
    pulse_start();
    repeat (2) @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 2'd0; cfg_wdata_i = 16'h0009;
    @(negedge clk); cfg_sel_i = 2'd1; cfg_wdata_i = 16'h1234;
    @(negedge clk); cfg_sel_i = 2'd2; cfg_wdata_i = 16'h0007;
    @(negedge clk); cfg_we_i = 1'b0; start_i = 1'b1; // R10
    @(negedge clk); start_i = 1'b0;
    wait_done();
    run_count("R8", 12);
    chk("R8", "seed kept", {16'h0, u_dut.scan_o, u_dut.pi_o} == 16'h1234 ? 32'h1 : 32'h0, 32'h0);

    // long hold, k=255 count=3; then single-word single-cycle boundary
    cfg(2'd0, 16'h00FF);
    cfg(2'd1, 16'h8001);
    cfg(2'd2, 16'h0003);
    run_count("R3", 765);
    cfg(2'd0, 16'h0001);
    cfg(2'd2, 16'h0001);
    run_count("R6", 1);
    summary();
  end

endmodule